// File: doc/BRIEF.md
# Power-On Reset Release Sequencer

This block produces the active-low system reset from the power-good flag of a primary supply rail, a pushbutton hard-reset request and a free-running clock. After the block's own reset is released, it runs a long one-time start-up timer. The reset output is held low until that timer has elapsed and the rail reports good. The output then goes high.

In service, a rail loss must last for a full deglitch window before reset asserts. Shorter dropouts are filtered out. A hard-reset request asserts reset on the next edge. Reset is released only after the rail has stayed good, with no hard-reset request, for a full release window. Any interruption during that window restarts the count.

At the edge where the start-up timer completes, the block samples an input-supply undervoltage flag. If the flag is high, a sticky undervoltage bit is set and the active-low interrupt output is pulled low. A clear strobe removes the bit. Every duration is a parameter counted in clock cycles.

Top module: `por_seq`

## Requirements
- R1: After `rst_ni` is released, `rst_no` stays low until STARTUP_CYC clock edges have passed. Once the timer is done, `rst_no` goes high on the first edge at which `rail_good_i` is high and `hard_rst_i` is low.
- R2: While `rst_no` is high, a run of fewer than DEGLITCH_CYC consecutive edges with `rail_good_i` low leaves `rst_no` high. Any edge with `rail_good_i` high restarts the run count from zero.
- R3: While `rst_no` is high, the DEGLITCH_CYC-th consecutive edge with `rail_good_i` low drives `rst_no` low.
- R4: Once the start-up timer is done, an edge with `hard_rst_i` high drives `rst_no` low. `rst_no` stays low for as long as `hard_rst_i` is held.
- R5: After `rst_no` has been driven low in service, it goes high on the RELEASE_CYC-th consecutive edge with `rail_good_i` high and `hard_rst_i` low. An edge that breaks this condition restarts the count from zero.
- R6: `vin_low_i` is sampled only at the edge where the start-up timer completes. If it is high there, `uv_flag_o` becomes 1 and `irq_no` becomes 0. `vin_low_i` has no effect at any other edge.
- R7: An edge with `uv_clr_i` high clears `uv_flag_o`, except at the setting edge of R6, where the set wins. `irq_no` is always the inverse of `uv_flag_o`.
- R8: While `rst_ni` is low, `rst_no` is 0, `irq_no` is 1 and `uv_flag_o` is 0, and the start-up timer restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| rail_good_i | input | 1 | Primary rail power-good, high when in regulation |
| hard_rst_i | input | 1 | Pushbutton hard-reset request, active high |
| vin_low_i | input | 1 | Input supply below undervoltage threshold |
| uv_clr_i | input | 1 | Clear strobe for the undervoltage bit |
| rst_no | output | 1 | System reset output, active low |
| irq_no | output | 1 | Interrupt output, active low |
| uv_flag_o | output | 1 | Sticky undervoltage status bit |

## Verification
On every cycle, the assertions check that reset cannot be released before the start-up timer is done. They also check that every rising edge of `rst_no` follows a sampled edge with the rail good and no hard reset, and that every falling edge follows a rail loss or a hard-reset request. They further check that a hard reset always pulls reset low, that the undervoltage bit can only rise together with timer completion while `vin_low_i` is high, and that a clear strobe empties it. The window lengths cannot be checked this way: the exact deglitch and release cycle counts, and the restart of each count after an interruption, come only from the bench scenarios. In those scenarios, a cycle-level reference model is compared against the outputs on every clock.

// File: rtl/por_seq_pkg.sv
package por_seq_pkg;
  typedef enum logic [1:0] {
    ST_INIT = 2'd0,
    ST_ON   = 2'd1,
    ST_DOWN = 2'd2
  } por_state_e;
endpackage

// File: rtl/por_startup_tmr.sv
module por_startup_tmr #(
  parameter int LEN = 50_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic done_o,
  output logic end_o
);
  localparam int W = $clog2(LEN + 1);

  logic [W-1:0] cnt_q;

  assign done_o = (cnt_q == W'(LEN));
  // high during the cycle whose closing edge completes the timer
  assign end_o  = (cnt_q == W'(LEN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!done_o) cnt_q <= cnt_q + W'(1);
  end
endmodule

// File: rtl/por_run_cnt.sv
module por_run_cnt #(
  parameter int LEN = 1250
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic hit_o
);
  localparam int W = (LEN > 1) ? $clog2(LEN + 1) : 1;

  logic [W-1:0] cnt_q;

  // hit on the LEN-th consecutive enabled edge
  assign hit_o = en_i && (cnt_q == W'(LEN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!en_i || hit_o)  cnt_q <= '0;
    else                      cnt_q <= cnt_q + W'(1);
  end
endmodule

// File: rtl/por_seq.sv
module por_seq
  import por_seq_pkg::*;
#(
  parameter int STARTUP_CYC  = 50_000_000,
  parameter int DEGLITCH_CYC = 1250,
  parameter int RELEASE_CYC  = 700_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rail_good_i,
  input  logic hard_rst_i,
  input  logic vin_low_i,
  input  logic uv_clr_i,
  output logic rst_no,
  output logic irq_no,
  output logic uv_flag_o
);
  por_state_e st_q, st_d;
  logic su_done, su_end;
  logic dg_en, dg_hit, rel_en, rel_hit;
  logic uv_q;

  por_startup_tmr #(.LEN(STARTUP_CYC)) u_su_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .done_o (su_done),
    .end_o  (su_end)
  );

  assign dg_en  = (st_q == ST_ON) && !rail_good_i;
  assign rel_en = (st_q == ST_DOWN) && rail_good_i && !hard_rst_i;

  por_run_cnt #(.LEN(DEGLITCH_CYC)) u_dg_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (dg_en),
    .hit_o  (dg_hit)
  );

  por_run_cnt #(.LEN(RELEASE_CYC)) u_rel_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (rel_en),
    .hit_o  (rel_hit)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_INIT: if (su_done && rail_good_i && !hard_rst_i) st_d = ST_ON;
      ST_ON:   if (hard_rst_i || dg_hit)                  st_d = ST_DOWN;
      ST_DOWN: if (rel_hit)                               st_d = ST_ON;
      default:                                            st_d = ST_INIT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_INIT;
    else         st_q <= st_d;
  end

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  uv_q <= 1'b0;
    else if (su_end && vin_low_i) uv_q <= 1'b1;
    else if (uv_clr_i)            uv_q <= 1'b0;
  end

  assign rst_no    = (st_q == ST_ON);
  assign uv_flag_o = uv_q;
  assign irq_no    = ~uv_q;
endmodule

// File: rtl/por_seq_chk.sv
module por_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic rail_good_i,
  input logic hard_rst_i,
  input logic vin_low_i,
  input logic uv_clr_i,
  input logic rst_no,
  input logic uv_flag_o,
  input logic su_done,
  input logic su_end
);
  // R1
  startup_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !su_done |-> !rst_no);

  // R5
  release_cond_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_no) |-> $past(rail_good_i && !hard_rst_i));

  // R3
  assert_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_no) |-> $past(hard_rst_i || !rail_good_i));

  // R4
  hard_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hard_rst_i && su_done) |=> !rst_no);

  // R6
  uv_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(uv_flag_o) |-> ($rose(su_done) && $past(vin_low_i)));

  // R7
  uv_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uv_clr_i && !(su_end && vin_low_i)) |=> !uv_flag_o);
endmodule

bind por_seq por_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rail_good_i (rail_good_i),
  .hard_rst_i  (hard_rst_i),
  .vin_low_i   (vin_low_i),
  .uv_clr_i    (uv_clr_i),
  .rst_no      (rst_no),
  .uv_flag_o   (uv_flag_o),
  .su_done     (su_done),
  .su_end      (su_end)
);

// File: tb/por_seq_tb_top.sv
module por_seq_tb_top;
  localparam int SU = 20;
  localparam int DG = 4;
  localparam int RL = 6;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic rail_good_i = 1'b0;
  logic hard_rst_i = 1'b0;
  logic vin_low_i = 1'b0;
  logic uv_clr_i = 1'b0;
  logic rst_no, irq_no, uv_flag_o;

  int tests = 0;
  int fails = 0;
  string tag = "R8";

  // reference model state
  int m_t, m_low_run, m_ok_run;
  bit m_up, m_ever, m_uv;

  always #10 clk_i = ~clk_i;

  por_seq #(.STARTUP_CYC(SU), .DEGLITCH_CYC(DG), .RELEASE_CYC(RL)) dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rail_good_i (rail_good_i),
    .hard_rst_i  (hard_rst_i),
    .vin_low_i   (vin_low_i),
    .uv_clr_i    (uv_clr_i),
    .rst_no      (rst_no),
    .irq_no      (irq_no),
    .uv_flag_o   (uv_flag_o)
  );

  task automatic chk(string req, logic act, logic exp, string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    if (!rst_ni) begin
      m_t = 0; m_low_run = 0; m_ok_run = 0; m_up = 0; m_ever = 0; m_uv = 0;
      return;
    end
    if (m_t == SU - 1 && vin_low_i) m_uv = 1;
    else if (uv_clr_i)              m_uv = 0;
    if (!m_ever) begin
      if (m_t >= SU && rail_good_i && !hard_rst_i) begin
        m_up = 1; m_ever = 1;
      end
    end else if (m_up) begin
      if (hard_rst_i) begin
        m_up = 0; m_low_run = 0; m_ok_run = 0;
      end else if (!rail_good_i) begin
        m_low_run++;
        if (m_low_run == DG) begin
          m_up = 0; m_low_run = 0; m_ok_run = 0;
        end
      end else m_low_run = 0;
    end else begin
      if (rail_good_i && !hard_rst_i) begin
        m_ok_run++;
        if (m_ok_run == RL) begin
          m_up = 1; m_ok_run = 0; m_low_run = 0;
        end
      end else m_ok_run = 0;
    end
    if (m_t < SU) m_t++;
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i);
      model_edge();
      @(negedge clk_i);
      chk(tag, rst_no, m_up, "rst_no");
      chk("R6", uv_flag_o, m_uv, "uv_flag_o");
      chk("R7", irq_no, !m_uv, "irq_no");
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk_i);
    tests++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    vin_low_i = 1'b1;
    @(negedge clk_i);
    tag = "R8";
    step(3);
    chk("R8", rst_no, 1'b0, "reset rst_no");
    chk("R8", irq_no, 1'b1, "reset irq_no");
    chk("R8", uv_flag_o, 1'b0, "reset uv_flag_o");

    // power-up with rail still bad, supply low at timer end
    rst_ni = 1'b1; tag = "R1";
    step(SU + 4);
    chk("R1", rst_no, 1'b0, "held low with rail bad");
    chk("R6", uv_flag_o, 1'b1, "uv captured");
    chk("R6", irq_no, 1'b0, "irq asserted");
    rail_good_i = 1'b1;
    step(1);
    chk("R1", rst_no, 1'b1, "released once rail good");

    // vin_low ignored outside timer end; then clear
    tag = "R6";
    for (int i = 0; i < 6; i++) begin
      vin_low_i = i[0];
      step(1);
    end
    vin_low_i = 1'b0;
    tag = "R7";
    uv_clr_i = 1'b1; step(1); uv_clr_i = 1'b0;
    chk("R7", uv_flag_o, 1'b0, "cleared");
    chk("R7", irq_no, 1'b1, "irq released");
    vin_low_i = 1'b1; step(3); vin_low_i = 1'b0;
    chk("R6", uv_flag_o, 1'b0, "late vin_low ignored");

    // short dropouts
    tag = "R2";
    rail_good_i = 1'b0; step(DG - 1);
    rail_good_i = 1'b1; step(1);
    rail_good_i = 1'b0; step(DG - 1);
    rail_good_i = 1'b1; step(1);
    rail_good_i = 1'b0; step(DG - 1);
    chk("R2", rst_no, 1'b1, "dropout filtered");
    rail_good_i = 1'b1; step(2);

    // long dropout
    tag = "R3";
    rail_good_i = 1'b0; step(DG);
    chk("R3", rst_no, 1'b0, "dropout asserts");
    step(2);

    // release with interruptions
    tag = "R5";
    rail_good_i = 1'b1; step(RL - 1);
    rail_good_i = 1'b0; step(1);
    rail_good_i = 1'b1; step(RL - 2);
    hard_rst_i = 1'b1; step(1); hard_rst_i = 1'b0;
    step(RL - 1);
    chk("R5", rst_no, 1'b0, "still counting");
    step(1);
    chk("R5", rst_no, 1'b1, "released after window");

    // hard reset
    tag = "R4";
    hard_rst_i = 1'b1; step(1);
    chk("R4", rst_no, 1'b0, "hard reset asserts");
    step(5);
    chk("R4", rst_no, 1'b0, "held by hard reset");
    hard_rst_i = 1'b0; tag = "R5";
    step(RL);
    chk("R5", rst_no, 1'b1, "released after hard reset");

    // second power-up, rail good throughout, supply fine
    tag = "R8";
    rst_ni = 1'b0; step(2);
    chk("R8", rst_no, 1'b0, "re-reset rst_no");
    vin_low_i = 1'b0; rail_good_i = 1'b1;
    rst_ni = 1'b1; tag = "R1";
    step(SU);
    chk("R1", rst_no, 1'b0, "low until timer done");
    step(1);
    chk("R1", rst_no, 1'b1, "high after timer");
    chk("R6", uv_flag_o, 1'b0, "no uv when supply ok");

    // third power-up: set wins over simultaneous clear
    tag = "R8";
    rst_ni = 1'b0; step(2);
    vin_low_i = 1'b1; uv_clr_i = 1'b1;
    rst_ni = 1'b1; tag = "R1";
    step(SU);
    chk("R7", uv_flag_o, 1'b1, "set wins over clear");
    step(1);
    chk("R7", uv_flag_o, 1'b0, "clear next edge");
    uv_clr_i = 1'b0; vin_low_i = 1'b0;
    step(2);

    finish_run();
  end
endmodule